// File: doc/BRIEF.md
# Cluster-Group Cache-Line Transfer Controller

This block moves one whole cache line at a time between a bank of shift-based storage tracks and a cache-side data bus. The tracks are arranged in clusters. A cluster holds one track per bus bit, and bit i of every bus word of a line lives in track i of the cluster. Each track holds one group of bits: the line size in bits divided by the bus width. The bit currently at a track's access port is the one that moves on the bus.

A line fill (read) or an eviction (write) is requested with a cluster index. The controller first moves the word at the port. It then shifts every track of the cluster by one position and moves the next word. This repeats until the whole line has crossed the bus, lowest word first. In a final cycle a single long shift returns the tracks to their home alignment. Addressing inside a group is not used, so every line transfer takes the same number of cycles. Each data beat completes on a valid/ready handshake. A beat the cache side has not accepted freezes the sequence.

Top module: `cgx_line_mover`

## Requirements
- R1: After synchronous reset, `busy`, `rd_valid` and `wr_ready` are low and every storage bit is zero, so a read of any cluster returns all-zero words.
- R2: A request (`req_valid` high with an in-range cluster) is accepted only while `busy` is low, and `busy` is high in the next cycle. A request presented while `busy` is high has no effect on data or timing.
- R3: A request whose cluster index is not below the number of clusters is ignored and `busy` stays low.
- R4: A read (`req_write` = 0) presents the line's words on `rd_data` with `rd_valid` high, word 0 (lowest address) first, in ascending order. Word k bit i is the bit held in track i of the cluster at group position k.
- R5: A write (`req_write` = 1) raises `wr_ready` for each beat, and the word taken on beat k becomes line word k of the selected cluster.
- R6: A beat without handshake (read: `rd_ready` low; write: `wr_valid` low) neither shifts the tracks nor advances the beat. A read beat keeps `rd_data` stable until it is taken.
- R7: With no stalls, `busy` is high for exactly G+1 cycles (G beats, then one rewind cycle during which `rd_valid` and `wr_ready` are low). Each stalled cycle adds exactly one cycle.
- R8: A transfer leaves all other clusters unchanged.
- R9: After a transfer the tracks are back at home alignment, so reading the same line again returns identical words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Line transfer request |
| req_write | input | 1 | 1 = eviction (write), 0 = line fill (read) |
| req_cluster | input | CLW | Cluster index of the request |
| busy | output | 1 | High from acceptance until the rewind cycle ends |
| rd_valid | output | 1 | Read word present on rd_data |
| rd_ready | input | 1 | Cache side takes the read word |
| rd_data | output | BUS_W | Read word |
| wr_valid | input | 1 | Write word present on wr_data |
| wr_ready | output | 1 | Controller takes the write word |
| wr_data | input | BUS_W | Write word |

## Verification
The bench builds the block with a 16-bit bus and 16-byte lines, giving eight-bit groups, and with three clusters. Three clusters is not a power of two, so the two-bit cluster index can carry the out-of-range value 3 and the rejection path can be exercised. Eight beats per line let random stalls land on the first, the middle and the last beat. That covers the step shift, the last-beat write without a shift, and the rewind from a full offset. Random stalls and requests injected while busy are checked against an exact cycle count for every transfer.

// File: rtl/cgx_pkg.sv
package cgx_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_BEAT   = 2'd1,
        SEQ_REWIND = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        TK_HOLD   = 2'd0,
        TK_STEP   = 2'd1,
        TK_LAST   = 2'd2,
        TK_REWIND = 2'd3
    } trk_op_e;

    typedef struct packed {
        trk_op_e op;
        logic    wr;
    } trk_cmd_t;

    function automatic int group_bits(input int line_bytes, input int bus_w);
        return (line_bytes * 8) / bus_w;
    endfunction

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cgx_track.sv
module cgx_track
    import cgx_pkg::*;
#(
    parameter int G = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  trk_cmd_t cmd,
    input  logic     wr_bit,
    output logic     port_bit
);
    localparam int REW = G - 1;

    logic [G-1:0] cells;
    logic [G-1:0] nxt;
    logic [G-1:0] home;
    logic         at_port;

    always_comb begin
        for (int i = 0; i < G; i++) begin
            home[i] = cells[(i + G - REW) % G];
        end
    end

    assign at_port = cmd.wr ? wr_bit : cells[0];

    always_comb begin
        unique case (cmd.op)
            TK_STEP:   nxt = {at_port, cells[G-1:1]};
            TK_LAST:   nxt = {cells[G-1:1], at_port};
            TK_REWIND: nxt = home;
            default:   nxt = cells;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cells <= '0;
        end else begin
            cells <= nxt;
        end
    end

    assign port_bit = cells[0];

    AST_TRACK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == TK_HOLD) |=> $stable(cells)); // R8

    AST_LAST_READ_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == TK_LAST && !cmd.wr) |=> $stable(cells)); // R9

endmodule

// File: rtl/cgx_cluster.sv
module cgx_cluster
    import cgx_pkg::*;
#(
    parameter int BUS_W = 64,
    parameter int G     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  trk_cmd_t         cmd,
    input  logic [BUS_W-1:0] wr_word,
    output logic [BUS_W-1:0] port_word
);
    for (genvar t = 0; t < BUS_W; t++) begin : g_trk
        cgx_track #(.G(G)) u_trk (
            .clk      (clk),
            .rst      (rst),
            .cmd      (cmd),
            .wr_bit   (wr_word[t]),
            .port_bit (port_word[t])
        );
    end

endmodule

// File: rtl/cgx_sequencer.sv
module cgx_sequencer
    import cgx_pkg::*;
#(
    parameter int G        = 8,
    parameter int CLUSTERS = 4,
    parameter int CLW      = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    input  logic           req_write,
    input  logic [CLW-1:0] req_cluster,
    input  logic           rd_ready,
    input  logic           wr_valid,
    output logic           busy,
    output logic           rd_valid,
    output logic           wr_ready,
    output logic [CLW-1:0] sel_cluster,
    output trk_cmd_t       cmd
);
    localparam int            GW       = idx_width(G);
    localparam logic [GW-1:0] LAST_IDX = GW'(G - 1);
    localparam logic [CLW:0]  CL_LIM   = (CLW + 1)'(CLUSTERS);

    seq_state_e     state;
    logic [GW-1:0]  cnt;
    logic [CLW-1:0] sel_q;
    logic           wr_q;
    logic           in_range;
    logic           accept;
    logic           hs;

    assign in_range = ({1'b0, req_cluster} < CL_LIM);
    assign accept   = (state == SEQ_IDLE) && req_valid && in_range;
    assign hs       = (state == SEQ_BEAT) && (wr_q ? wr_valid : rd_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
            sel_q <= '0;
            wr_q  <= 1'b0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    if (accept) begin
                        state <= SEQ_BEAT;
                        cnt   <= '0;
                        sel_q <= req_cluster;
                        wr_q  <= req_write;
                    end
                end
                SEQ_BEAT: begin
                    if (hs) begin
                        if (cnt == LAST_IDX) begin
                            state <= SEQ_REWIND;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd.wr = wr_q;
        if (hs) begin
            cmd.op = (cnt == LAST_IDX) ? TK_LAST : TK_STEP;
        end else if (state == SEQ_REWIND) begin
            cmd.op = TK_REWIND;
        end else begin
            cmd.op = TK_HOLD;
        end
    end

    assign busy        = (state != SEQ_IDLE);
    assign rd_valid    = (state == SEQ_BEAT) && !wr_q;
    assign wr_ready    = (state == SEQ_BEAT) && wr_q;
    assign sel_cluster = sel_q;

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && in_range) |=> busy); // R2

    AST_BUSY_KEEPS_REQ: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_BEAT) |=> ($stable(sel_q) && $stable(wr_q))); // R2

    AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && !in_range) |=> !busy); // R3

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_BEAT && !hs) |=> (state == SEQ_BEAT && $stable(cnt))); // R6

    AST_ONE_REWIND: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_REWIND) |=> !busy); // R7

endmodule

// File: rtl/cgx_line_mover.sv
module cgx_line_mover
    import cgx_pkg::*;
#(
    parameter int BUS_W      = 64,
    parameter int LINE_BYTES = 64,
    parameter int CLUSTERS   = 4,
    parameter int CLW        = idx_width(CLUSTERS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [CLW-1:0]   req_cluster,
    output logic             busy,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [BUS_W-1:0] rd_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [BUS_W-1:0] wr_data
);
    localparam int G = group_bits(LINE_BYTES, BUS_W);

    trk_cmd_t       cmd;
    logic [CLW-1:0] sel;
    logic [BUS_W-1:0] cl_word [CLUSTERS];

    cgx_sequencer #(
        .G        (G),
        .CLUSTERS (CLUSTERS),
        .CLW      (CLW)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_cluster (req_cluster),
        .rd_ready    (rd_ready),
        .wr_valid    (wr_valid),
        .busy        (busy),
        .rd_valid    (rd_valid),
        .wr_ready    (wr_ready),
        .sel_cluster (sel),
        .cmd         (cmd)
    );

    for (genvar c = 0; c < CLUSTERS; c++) begin : g_cl
        trk_cmd_t c_cmd;
        assign c_cmd = (sel == CLW'(c)) ? cmd : trk_cmd_t'{op: TK_HOLD, wr: 1'b0};

        cgx_cluster #(
            .BUS_W (BUS_W),
            .G     (G)
        ) u_cl (
            .clk       (clk),
            .rst       (rst),
            .cmd       (c_cmd),
            .wr_word   (wr_data),
            .port_word (cl_word[c])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < CLUSTERS; c++) begin
            if (sel == CLW'(c)) begin
                rd_data = cl_word[c];
            end
        end
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R6

    AST_EXCLUSIVE_DIR: assert property (@(posedge clk) disable iff (rst)
        !(rd_valid && wr_ready)); // R4

endmodule

// File: tb/cgx_line_mover_bench.sv
module cgx_line_mover_bench;
    localparam int BW  = 16;
    localparam int LB  = 16;
    localparam int CL  = 3;
    localparam int CLW = 2;
    localparam int G   = (LB * 8) / BW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [CLW-1:0] req_cluster = '0;
    logic          busy, rd_valid, wr_ready;
    logic          rd_ready = 1'b0;
    logic          wr_valid = 1'b0;
    logic [BW-1:0] rd_data;
    logic [BW-1:0] wr_data = '0;

    int n_checks = 0;
    int n_fails  = 0;

    logic [BW-1:0] mem [CL][G];
    logic [BW-1:0] line_buf [G];

    always #5 clk = ~clk;

    cgx_line_mover #(
        .BUS_W(BW), .LINE_BYTES(LB), .CLUSTERS(CL), .CLW(CLW)
    ) u_cgx_line_mover (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_cluster(req_cluster), .busy(busy), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .rd_data(rd_data), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_data(wr_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic bit coin(input int pct);
        return ($urandom % 100) < pct;
    endfunction

    task automatic do_read(input int c, input int stall, input bit intrude, input string tag);
        int k = 0;
        int cyc;
        int stalls = 0;
        req_valid = 1'b1; req_write = 1'b0; req_cluster = CLW'(c);
        tick();
        req_valid = 1'b0;
        cyc = 1;
        chk(busy, "R2", 32'(busy), 32'd1);
        while (k < G) begin
            rd_ready = !coin(stall);
            chk(rd_valid && rd_data == mem[c][k], tag, 32'(rd_data), 32'(mem[c][k]));
            if (intrude && k == 2) begin
                req_valid = 1'b1; req_write = 1'b1; req_cluster = CLW'((c + 1) % CL);
            end
            tick();
            req_valid = 1'b0;
            cyc++;
            if (rd_ready) k++; else stalls++;
        end
        rd_ready = 1'b0;
        chk(busy && !rd_valid, "R7", {30'd0, busy, rd_valid}, 32'd2);
        chk(cyc == G + 1 + stalls, "R7", 32'(cyc), 32'(G + 1 + stalls));
        tick();
        chk(!busy, "R7", 32'(busy), 32'd0);
    endtask

    task automatic do_write(input int c, input int stall, input bit intrude);
        int k = 0;
        int cyc;
        int stalls = 0;
        req_valid = 1'b1; req_write = 1'b1; req_cluster = CLW'(c);
        tick();
        req_valid = 1'b0;
        cyc = 1;
        chk(busy, "R2", 32'(busy), 32'd1);
        while (k < G) begin
            wr_valid = !coin(stall);
            wr_data  = wr_valid ? line_buf[k] : BW'($urandom);
            chk(wr_ready && !rd_valid, "R5", 32'(wr_ready), 32'd1);
            if (intrude && k == 1) begin
                req_valid = 1'b1; req_write = 1'b0; req_cluster = CLW'((c + 2) % CL);
            end
            tick();
            req_valid = 1'b0;
            cyc++;
            if (wr_valid) k++; else stalls++;
        end
        wr_valid = 1'b0;
        chk(busy && !wr_ready, "R7", {30'd0, busy, wr_ready}, 32'd2);
        chk(cyc == G + 1 + stalls, "R6", 32'(cyc), 32'(G + 1 + stalls));
        tick();
        chk(!busy, "R7", 32'(busy), 32'd0);
        for (int j = 0; j < G; j++) mem[c][j] = line_buf[j];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < CL; c++)
            for (int j = 0; j < G; j++) mem[c][j] = '0;
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;
        // R1: reset state at the ports
        chk(!busy && !rd_valid && !wr_ready, "R1", {29'd0, busy, rd_valid, wr_ready}, 32'd0);
        for (int c = 0; c < CL; c++) do_read(c, 0, 1'b0, "R1");

        // R5 / R4: ascending words, no stalls
        for (int j = 0; j < G; j++) line_buf[j] = BW'(16'hA100 + j);
        do_write(0, 0, 1'b0);
        do_read(0, 0, 1'b0, "R4");
        do_read(0, 40, 1'b0, "R9");

        // R6: stalled write, R8: neighbours untouched
        for (int j = 0; j < G; j++) line_buf[j] = ~BW'(j * 257);
        do_write(2, 50, 1'b0);
        do_read(1, 0, 1'b0, "R8");
        do_read(2, 50, 1'b0, "R6");
        do_read(0, 0, 1'b0, "R8");

        // R3: out-of-range cluster index ignored
        req_valid = 1'b1; req_write = 1'b1; req_cluster = 2'd3;
        tick();
        req_valid = 1'b0;
        chk(!busy && !wr_ready, "R3", 32'(busy), 32'd0);
        tick();
        chk(!busy, "R3", 32'(busy), 32'd0);
        do_read(0, 0, 1'b0, "R3");

        // R2: requests while busy ignored
        for (int j = 0; j < G; j++) line_buf[j] = BW'($urandom);
        do_write(1, 20, 1'b1);
        do_read(1, 20, 1'b1, "R2");
        do_read(2, 0, 1'b0, "R2");

        // random mix
        for (int it = 0; it < 40; it++) begin
            int c = $urandom % CL;
            int st = $urandom % 60;
            if (coin(50)) begin
                for (int j = 0; j < G; j++) line_buf[j] = BW'($urandom);
                do_write(c, st, coin(30));
            end else begin
                do_read(c, st, coin(30), "R4");
            end
            repeat ($urandom % 3) tick();
        end
        for (int c = 0; c < CL; c++) do_read(c, 10, 1'b0, "R9");

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule